// File: doc/BRIEF.md
# Security-Zoned Retained Register Bank

This block is a bank of 32 retained 32-bit registers that sits behind a plain memory-mapped register interface. It has one read port and one write port, and each port carries its own secure/non-secure attribute. Two programmable border indices split the bank into three contiguous zones:

- a low zone that only secure accesses may touch;
- a middle zone that secure accesses may write and that any access may read;
- a high zone that is open to everyone.

The border values live in two extra words placed just above the register array. Only secure writes may change them. A denied write is dropped. A denied read returns zero. In both cases a one-cycle error pulse is raised.

The bank has two resets. The stored contents survive the ordinary system reset and are cleared only by the power-on reset. The system reset returns the borders to their default values and clears the response outputs. A typical use is keeping boot and wake-up state across warm resets, while firmware running in the secure world decides how much of the bank the non-secure world may see or change.

Top module: `bkreg_zone_bank`

## Requirements
- R1: The bank holds 32 registers of 32 bits. Register n sits at byte offset 4*n, so the word index is address bits [7:2]. Address bits [1:0] are ignored.
- R2: Registers whose index is below the effective middle border form the secure zone. A non-secure read or write to this zone is denied.
- R3: A denied read still gives rsp_valid one cycle later. In that cycle rsp_rdata is all zeros and access_err is high for exactly one cycle.
- R4: Registers from the effective middle border up to, but not including, the open border form the shared zone. A non-secure read there returns the stored value. A non-secure write there is denied, raises access_err and leaves the register unchanged.
- R5: Registers at or above the open border accept reads and writes from both secure and non-secure accesses.
- R6: Word index 32 (byte 0x80) holds the middle border and word index 33 (byte 0x84) holds the open border. Both values sit in bits [5:0]. Any access may read them. Only a secure write may change them. A non-secure write to either one is denied and leaves both unchanged. After any reset the middle border is 10 and the open border is 15.
- R7: A border value written above 32 is stored as 32. The effective middle border is the smaller of the two stored borders, and a read of index 32 returns that effective value.
- R8: rsp_valid and rsp_rdata appear exactly one cycle after rd_en. rsp_rdata is zero in every cycle that does not follow a read.
- R9: If a read and a write target the same index in the same cycle, the read returns the old value. A later read returns the new one.
- R10: Word indices 34 to 63 are unmapped. A read there returns zero with access_err high. A write there is dropped with access_err high.
- R11: While rst_n is low, the borders take their defaults and rsp_valid, rsp_rdata and access_err are zero, but register contents are kept. While por_n is low, all of that happens and every register is also cleared to zero.
- R12: access_err is high in the cycle after a denied read or a denied write, including both in the same cycle. It is never high after a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears the contents |
| rst_n | input | 1 | System reset, active low, asynchronous; contents retained |
| rd_en | input | 1 | Read request |
| rd_sec | input | 1 | Read carries the secure attribute |
| rd_addr | input | 8 | Read byte address |
| wr_en | input | 1 | Write request |
| wr_sec | input | 1 | Write carries the secure attribute |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe, one cycle after rd_en |
| rsp_rdata | output | 32 | Read data, zero on denial or when idle |
| access_err | output | 1 | One-cycle pulse on a denied read or write |

## Verification
A wrong border or zone decision in this block shows up at the ports on the very next cycle. It appears either as a missing or unexpected access_err pulse, or as zero data where stored data was due. A write that was dropped or wrongly accepted stays hidden until that index is read back. For that reason the bench reads every index back after each write sweep and each border change, so a corrupted cell is exposed within one sweep. Retention faults are caught by reading the whole bank after a system reset and again after a power-on reset.

// File: rtl/bkreg_pkg.sv
package bkreg_pkg;

   // Access class of a register index, ordered from most to least restricted.
   typedef enum logic [1:0] {
      ZN_SECURE    = 2'd0,
      ZN_SHARED_RD = 2'd1,
      ZN_OPEN      = 2'd2
   } zone_e;

endpackage

// File: rtl/bkreg_border_cfg.sv
module bkreg_border_cfg #(
   parameter int NREGS    = 32,
   parameter int IW       = 6,
   parameter int DEF_MID  = 10,
   parameter int DEF_OPEN = 15,
   parameter int PROG     = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic          wr_sel,
   input  logic [IW-1:0] wr_val,
   output logic [IW-1:0] mid_eff,
   output logic [IW-1:0] open_q
);

   localparam logic [IW-1:0] MAXV = IW'(NREGS);

   logic [IW-1:0] sat_val;
   assign sat_val = (wr_val > MAXV) ? MAXV : wr_val;

   generate
      if (PROG != 0) begin : g_prog
         logic [IW-1:0] mid_q;
         logic [IW-1:0] opn_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mid_q <= IW'(DEF_MID);
               opn_q <= IW'(DEF_OPEN);
            end else if (wr_stb) begin
               if (wr_sel) opn_q <= sat_val;
               else        mid_q <= sat_val;
            end
         end

         assign mid_eff = (mid_q > opn_q) ? opn_q : mid_q;
         assign open_q  = opn_q;
      end else begin : g_fixed
         logic unused_fixed;
         assign unused_fixed = ^{clk, rst_n, wr_stb, wr_sel, sat_val};
         assign mid_eff = IW'(DEF_MID);
         assign open_q  = IW'(DEF_OPEN);
      end
   endgenerate

endmodule

// File: rtl/bkreg_zone_check.sv
module bkreg_zone_check
   import bkreg_pkg::*;
#(
   parameter int NREGS = 32,
   parameter int IW    = 6
) (
   input  logic [IW-1:0] idx,
   input  logic          secure,
   input  logic          write,
   input  logic [IW-1:0] b_mid,
   input  logic [IW-1:0] b_open,
   output logic          is_reg,
   output logic          is_bord,
   output logic          bord_sel,
   output logic          allow
);

   localparam logic [IW-1:0] IDX_MID  = IW'(NREGS);
   localparam logic [IW-1:0] IDX_OPEN = IW'(NREGS + 1);

   zone_e zone;

   assign is_reg   = (idx < IDX_MID);
   assign is_bord  = (idx == IDX_MID) || (idx == IDX_OPEN);
   assign bord_sel = (idx == IDX_OPEN);

   always_comb begin
      if (idx < b_mid)       zone = ZN_SECURE;
      else if (idx < b_open) zone = ZN_SHARED_RD;
      else                   zone = ZN_OPEN;
   end

   always_comb begin
      if (is_reg) begin
         unique case (zone)
            ZN_SECURE:    allow = secure;
            ZN_SHARED_RD: allow = secure || !write;
            default:      allow = 1'b1;
         endcase
      end else if (is_bord) begin
         allow = secure || !write;
      end else begin
         allow = 1'b0;
      end
   end

endmodule

// File: rtl/bkreg_store.sv
module bkreg_store #(
   parameter int NREGS = 32,
   parameter int DW    = 32,
   parameter int IW    = 6
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] ridx,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] cells [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_cell
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                         q <= '0;
         else if (we && (widx == IW'(g)))    q <= wdata;
      end
      assign cells[g] = q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREGS; i++) begin
         if (ridx == IW'(i)) rdata = cells[i];
      end
   end

endmodule

// File: rtl/bkreg_zone_bank.sv
module bkreg_zone_bank #(
   parameter int NREGS        = 32,
   parameter int DW           = 32,
   parameter int DEF_MID      = 10,
   parameter int DEF_OPEN     = 15,
   parameter int PROG_BORDERS = 1,
   localparam int IW          = $clog2(NREGS + 2),
   localparam int AW          = IW + 2
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          rd_sec,
   input  logic [AW-1:0] rd_addr,
   input  logic          wr_en,
   input  logic          wr_sec,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          access_err
);

   localparam bit PROG_B = (PROG_BORDERS != 0);

   // Elaboration-time parameter checks
   if (NREGS < 2)                        $error("NREGS must be at least 2");
   if (DW < IW)                          $error("DW must hold a border value");
   if (DEF_MID < 0 || DEF_MID > DEF_OPEN) $error("DEF_MID out of range");
   if (DEF_OPEN > NREGS)                 $error("DEF_OPEN above NREGS");

   logic          sys_rst_n;
   logic [IW-1:0] rd_idx, wr_idx;
   logic [IW-1:0] b_mid, b_open;
   logic          rd_is_reg, rd_is_bord, rd_bsel, rd_allow;
   logic          wr_is_reg, wr_is_bord, wr_bsel, wr_allow;
   logic          rd_ok, wr_ok;
   logic [DW-1:0] store_rd, border_rd;
   logic          unused_lsb;

   assign sys_rst_n  = rst_n & por_n;
   assign rd_idx     = rd_addr[AW-1:2];
   assign wr_idx     = wr_addr[AW-1:2];
   assign unused_lsb = ^{rd_addr[1:0], wr_addr[1:0]};

   bkreg_zone_check #(.NREGS(NREGS), .IW(IW)) u_rd_chk (
      .idx(rd_idx), .secure(rd_sec), .write(1'b0),
      .b_mid(b_mid), .b_open(b_open),
      .is_reg(rd_is_reg), .is_bord(rd_is_bord), .bord_sel(rd_bsel), .allow(rd_allow)
   );

   bkreg_zone_check #(.NREGS(NREGS), .IW(IW)) u_wr_chk (
      .idx(wr_idx), .secure(wr_sec), .write(1'b1),
      .b_mid(b_mid), .b_open(b_open),
      .is_reg(wr_is_reg), .is_bord(wr_is_bord), .bord_sel(wr_bsel), .allow(wr_allow)
   );

   assign rd_ok = rd_allow;
   assign wr_ok = wr_allow && (wr_is_reg || PROG_B);

   bkreg_border_cfg #(
      .NREGS(NREGS), .IW(IW), .DEF_MID(DEF_MID), .DEF_OPEN(DEF_OPEN), .PROG(PROG_BORDERS)
   ) u_border (
      .clk(clk), .rst_n(sys_rst_n),
      .wr_stb(wr_en && wr_ok && wr_is_bord), .wr_sel(wr_bsel), .wr_val(wr_data[IW-1:0]),
      .mid_eff(b_mid), .open_q(b_open)
   );

   bkreg_store #(.NREGS(NREGS), .DW(DW), .IW(IW)) u_store (
      .clk(clk), .por_n(por_n),
      .we(wr_en && wr_ok && wr_is_reg), .widx(wr_idx), .wdata(wr_data),
      .ridx(rd_idx), .rdata(store_rd)
   );

   assign border_rd = rd_bsel ? DW'(b_open) : DW'(b_mid);

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         access_err <= 1'b0;
      end else begin
         rsp_valid  <= rd_en;
         access_err <= (rd_en && !rd_ok) || (wr_en && !wr_ok);
         if (rd_en && rd_ok) rsp_rdata <= rd_is_reg ? store_rd : border_rd;
         else                rsp_rdata <= '0;
      end
   end

   logic unused_rd_bord;
   assign unused_rd_bord = rd_is_bord;

endmodule

// File: rtl/bkreg_zone_bank_chk.sv
module bkreg_zone_bank_chk #(
   parameter int NREGS = 32,
   parameter int DW    = 32,
   localparam int IW   = $clog2(NREGS + 2),
   localparam int AW   = IW + 2
) (
   input logic          clk,
   input logic          por_n,
   input logic          rst_n,
   input logic          rd_en,
   input logic          rd_sec,
   input logic [AW-1:0] rd_addr,
   input logic          wr_en,
   input logic          wr_sec,
   input logic [AW-1:0] wr_addr,
   input logic          rsp_valid,
   input logic [DW-1:0] rsp_rdata,
   input logic          access_err,
   input logic [IW-1:0] b_mid,
   input logic [IW-1:0] b_open
);

   localparam logic [IW-1:0] LAST = IW'(NREGS);

   logic [IW-1:0] rd_idx, wr_idx;
   logic          unused_chk;
   assign rd_idx     = rd_addr[AW-1:2];
   assign wr_idx     = wr_addr[AW-1:2];
   assign unused_chk = ^{rd_addr[1:0], wr_addr[1:0]};

   p_rsp_after_read_r8: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
      rd_en |=> rsp_valid);

   p_no_rsp_idle_r8: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
      !rd_en |=> (!rsp_valid && rsp_rdata == '0));

   p_ns_secure_read_zero_r3: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
      (rd_en && !rd_sec && rd_idx < b_mid) |=> (access_err && rsp_rdata == '0));

   p_ns_shared_write_err_r4: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
      (wr_en && !wr_sec && wr_idx < b_open) |=> access_err);

   p_border_ns_hold_r6: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
      (wr_en && !wr_sec && wr_idx >= LAST) |=> ($stable(b_mid) && $stable(b_open)));

   p_unmapped_read_err_r10: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
      (rd_en && rd_idx > LAST + IW'(1)) |=> (access_err && rsp_rdata == '0));

   p_no_err_idle_r12: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
      (!rd_en && !wr_en) |=> !access_err);

   p_border_order_r7: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
      (b_mid <= b_open) && (b_open <= LAST));

endmodule

bind bkreg_zone_bank bkreg_zone_bank_chk #(.NREGS(NREGS), .DW(DW)) u_chk (
   .clk(clk), .por_n(por_n), .rst_n(rst_n),
   .rd_en(rd_en), .rd_sec(rd_sec), .rd_addr(rd_addr),
   .wr_en(wr_en), .wr_sec(wr_sec), .wr_addr(wr_addr),
   .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .access_err(access_err),
   .b_mid(b_mid), .b_open(b_open)
);

// File: tb/bkreg_zone_bank_tb.sv
module bkreg_zone_bank_tb;

   logic        clk = 1'b0;
   logic        por_n, rst_n;
   logic        rd_en, rd_sec, wr_en, wr_sec;
   logic [7:0]  rd_addr, wr_addr;
   logic [31:0] wr_data;
   logic        rsp_valid, access_err;
   logic [31:0] rsp_rdata;

   always #5 clk = ~clk;

   bkreg_zone_bank u_dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .rd_en(rd_en), .rd_sec(rd_sec), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_sec(wr_sec), .wr_addr(wr_addr), .wr_data(wr_data),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .access_err(access_err)
   );

   // Behavioural reference state
   int unsigned m_mem [32];
   int          m_mid, m_open;
   bit          e_v, e_e;
   int unsigned e_d;
   int          n_vec = 0, n_bad = 0;
   bit          done = 0;

   function automatic logic [7:0] ba(int idx, int lsb = 0);
      return 8'((idx << 2) | lsb);
   endfunction

   task automatic model_reset(bit por);
      m_mid = 10; m_open = 15;
      if (por) foreach (m_mem[i]) m_mem[i] = 0;
      e_v = 0; e_d = 0; e_e = 0;
   endtask

   // Predict the outputs of the next edge from the present inputs, then update state.
   task automatic model_step();
      int  eff, ri, wi, v;
      bit  rok, wok;
      eff = (m_mid > m_open) ? m_open : m_mid;
      ri = int'(rd_addr[7:2]); wi = int'(wr_addr[7:2]);
      rok = 1; wok = 1; e_d = 0;
      if (rd_en) begin
         if (ri < 32) begin
            rok = rd_sec || ri >= eff;
            if (rok) e_d = m_mem[ri];
         end else if (ri == 32) e_d = eff;
         else if (ri == 33)     e_d = m_open;
         else                   rok = 0;
      end
      if (wr_en) begin
         if (wi < 32) begin
            wok = wr_sec || wi >= m_open;
            if (wok) m_mem[wi] = wr_data;
         end else if (wi == 32 || wi == 33) begin
            wok = wr_sec;
            v = int'(wr_data[5:0]);
            if (v > 32) v = 32;
            if (wok) begin
               if (wi == 32) m_mid = v; else m_open = v;
            end
         end else wok = 0;
      end
      e_v = rd_en;
      e_e = (rd_en && !rok) || (wr_en && !wok);
   endtask

   task automatic compare(string tag);
      n_vec++;
      if (rsp_valid !== e_v || rsp_rdata !== e_d || access_err !== e_e) begin
         n_bad++;
         $display("FAIL %s: got v=%0b d=%08h e=%0b, expected v=%0b d=%08h e=%0b",
                  tag, rsp_valid, rsp_rdata, access_err, e_v, e_d, e_e);
      end
   endtask

   task automatic cyc(string tag, bit re, bit rs, int ridx, bit we, bit ws, int widx,
                      int unsigned wd, int rlsb = 0);
      rd_en = re; rd_sec = rs; rd_addr = ba(ridx, rlsb);
      wr_en = we; wr_sec = ws; wr_addr = ba(widx); wr_data = wd;
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle();
      rd_en = 0; wr_en = 0; rd_sec = 0; wr_sec = 0;
      rd_addr = 0; wr_addr = 0; wr_data = 0;
   endtask

   task automatic do_reset(bit por, string tag);
      idle();
      if (por) por_n = 0; else rst_n = 0;
      model_reset(por);
      @(negedge clk);
      compare(tag);
      @(negedge clk);
      por_n = 1; rst_n = 1;
   endtask

   task automatic read_all(string tag, bit sec);
      for (int i = 0; i < 34; i++) cyc(tag, 1, sec, i, 0, 0, 0, 0);
   endtask

   task automatic write_all(string tag, bit sec, int unsigned salt);
      for (int i = 0; i < 32; i++) cyc(tag, 0, 0, 0, 1, sec, i, salt ^ (i * 32'h01010101));
   endtask

   initial begin
      por_n = 0; rst_n = 0; idle();
      model_reset(1);
      @(negedge clk);
      do_reset(1, "R11 por state");
      cyc("R11 idle after reset", 0, 0, 0, 0, 0, 0, 0);

      // R1 R5: secure fill, then secure readback with address LSBs set
      write_all("R1 secure fill", 1, 32'hA5C3_0000);
      for (int i = 0; i < 32; i++) cyc("R1 readback lsb", 1, 1, i, 0, 0, 0, 0, i % 4);
      // R2 R3 R4 R5: non-secure read sweep with default borders
      read_all("R3 ns read sweep", 0);
      // R2 R4 R5: non-secure writes, then secure check of contents
      write_all("R4 ns write sweep", 0, 32'h3C00_F00D);
      read_all("R2 secure verify", 1);
      // R9: read and write same index in the same cycle
      cyc("R9 same-cycle old", 1, 1, 20, 1, 1, 20, 32'hDEAD_BEEF);
      cyc("R9 new value", 1, 1, 20, 0, 0, 0, 0);
      cyc("R9 border same-cycle", 1, 0, 33, 1, 1, 33, 33);
      // R6: non-secure border writes denied
      cyc("R6 ns mid write", 0, 0, 0, 1, 0, 32, 2);
      cyc("R6 ns open write", 1, 0, 32, 1, 0, 33, 3);
      cyc("R6 readback", 1, 0, 33, 0, 0, 0, 0);
      // Move borders: open 20, mid 5
      cyc("R6 set open", 0, 0, 0, 1, 1, 33, 20);
      cyc("R6 set mid", 0, 0, 0, 1, 1, 32, 5);
      read_all("R2 ns read moved", 0);
      write_all("R4 ns write moved", 0, 32'h0BAD_0000);
      read_all("R5 verify moved", 1);
      // R7: clamping and saturation
      cyc("R7 mid above open", 1, 0, 32, 1, 1, 32, 25);
      cyc("R7 mid clamped", 1, 0, 32, 0, 0, 0, 0);
      read_all("R7 ns clamped zones", 0);
      cyc("R7 open saturate", 0, 0, 0, 1, 1, 33, 32'h0000_0028);
      cyc("R7 open readback", 1, 1, 33, 0, 0, 0, 0);
      write_all("R7 ns write all shared", 0, 32'h1234_0000);
      read_all("R7 verify", 0);
      cyc("R6 open zero", 0, 0, 0, 1, 1, 33, 0);
      cyc("R6 mid zero", 0, 0, 0, 1, 1, 32, 0);
      write_all("R5 ns write open", 0, 32'h5555_0000);
      read_all("R5 ns read open", 0);
      // R10: unmapped indices
      for (int i = 34; i < 64; i += 7) cyc("R10 unmapped", 1, 1, i, 1, 1, i, 32'hFFFF_FFFF);
      cyc("R10 unmapped high", 1, 0, 63, 1, 0, 63, 1);
      // R12: both denied in one cycle, and one denied with one allowed
      cyc("R6 restore open", 0, 0, 0, 1, 1, 33, 15);
      cyc("R6 restore mid", 0, 0, 0, 1, 1, 32, 10);
      cyc("R12 both denied", 1, 0, 3, 1, 0, 12, 7);
      cyc("R12 write only denied", 1, 0, 16, 1, 0, 4, 7);
      cyc("R12 read only denied", 1, 0, 2, 1, 0, 25, 7);
      cyc("R8 idle", 0, 0, 0, 0, 0, 0, 0);
      // R11: system reset keeps contents, power-on reset clears them
      cyc("R11 move open", 0, 0, 0, 1, 1, 33, 30);
      do_reset(0, "R11 sys reset state");
      read_all("R11 retained", 1);
      do_reset(1, "R11 por again");
      read_all("R11 cleared", 1);
      // Mixed random traffic
      for (int k = 0; k < 3000; k++) begin
         int unsigned r = $urandom;
         cyc("R12 mixed", r[0], r[1], int'(r[9:4]) % 36, r[2], r[3] | r[13], int'(r[15:10]) % 36,
             (r[3] && r[14]) ? (r >> 24) % 40 : $urandom, int'(r[17:16]));
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule